// File: doc/BRIEF.md
# Leveled Interrupt Request Controller

This block sits between a chip's interrupt sources and its CPU. Each of 27 source lines belongs to one of eight interrupt levels. When a source fires and its level is not masked, the level's request bit is latched. The controller keeps a request register, a mask register, a priority-order register and a mode register. It picks one pending level and offers it to the CPU.

The CPU-facing side is a valid/ready channel carrying a level number and a fast flag. The controller registers the choice and raises `irq_valid`. The offered level and fast flag stay frozen until the CPU takes them by asserting `irq_ready`. This holds even when a more urgent level arrives or software changes the registers. The CPU therefore applies back-pressure simply by holding `irq_ready` low.

A transfer happens on a clock edge where `irq_valid` and `irq_ready` are both high. On that edge the granted level's request bit is cleared. On the same edge a fresh choice is loaded, and that choice leaves out the level just granted. One level can be marked as the fast level. When it is enabled and pending, it is offered ahead of the normal order, with `irq_fast` set.

Top module: `irq_lvl_ctrl`

## Requirements
- R1: After reset the registers read as follows: request 0x00, mask 0xFF, priority 0x00, mode 0x00. `irq_valid` is 0.
- R2: Source i belongs to level floor(i*8/27). An active source on an unmasked level sets that level's request bit on the next clock edge.
- R3: A mask bit of 1 blocks its level. Source activity on a masked level never sets that level's request bit.
- R4: A write to the request register clears every bit where the written data is 0. Bits where the data is 1 keep their value, so software cannot set a request.
- R5: While mode bit 0 (global enable) is 0, no offer is made (`irq_valid` stays 0), even with requests pending. Pending means the request bit is 1 and the mask bit is 0.
- R6: The priority code is the priority register's bits 2:0. Code 7 offers the highest-numbered pending level. Every other code, reserved ones included, offers the lowest-numbered pending level.
- R7: Mode bit 1 enables the fast level, and mode bits 4:2 select it. If fast is enabled and the selected level is pending, that level is offered with `irq_fast`=1, overriding R6. Every other offer carries `irq_fast`=0.
- R8: While `irq_valid`=1 and `irq_ready`=0, the values of `irq_valid`, `irq_level` and `irq_fast` are held. On an accepting edge the offered level's request bit clears, and the next offer is loaded from the remaining pending levels.
- R9: The register address map is 0 request, 1 mask, 2 priority and 3 mode. The priority register keeps only bits 2:0. The mode register keeps bits 4:0, and bits 7:5 read as 0.
- R10: If a source is active on the same edge as a clear of its level, the set wins. The clear may come from a software write or from an acceptance.
- R11: An offer appears on the clock edge after its request bit was latched, so it comes two edges after the source was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Interrupt source lines, sampled each edge |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 request, 1 mask, 2 priority, 3 mode) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| irq_valid | output | 1 | An interrupt level is being offered |
| irq_ready | input | 1 | CPU takes the offer |
| irq_level | output | LVL_W | Offered level |
| irq_fast | output | 1 | Offer is the fast level |

## Verification
The bench pulses sources on the level boundaries (sources 3/4 and 10/11). A mapping that is off by one would latch the wrong request bit. It also holds a level offered while a more urgent one arrives. A design that re-arbitrates under back-pressure would switch `irq_level` before the handshake. Further cases cover a reserved priority code, a fast level that is selected but not pending, and a fast level enabled while global enable is off. Getting these wrong shows up as an inverted order, a stray `irq_fast`, or an offer that should have been suppressed. A final pair of cases drives a source while its level is being cleared, by a write and by an acceptance. Giving the clear priority would silently lose that event.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int PRIO_W = 3;
  localparam logic [PRIO_W-1:0] PRIO_DESC = 3'b111;

  typedef enum logic [1:0] {
    ADDR_REQ  = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_PRIO = 2'd2,
    ADDR_MODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_lvl_capture.sv
module irq_lvl_capture #(
  parameter int NUM_SRC = 27,
  parameter int NUM_LVL = 8
) (
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_LVL-1:0] lvl_hit
);
  // Sources are spread evenly: source i belongs to level floor(i*NUM_LVL/NUM_SRC)
  function automatic logic [NUM_SRC-1:0] members(input int lvl);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if ((i * NUM_LVL) / NUM_SRC == lvl) m[i] = 1'b1;
    return m;
  endfunction

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam logic [NUM_SRC-1:0] MEMB = members(l);
    assign lvl_hit[l] = |(src_req & MEMB);
  end
endmodule

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int DATA_W  = 8,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_LVL-1:0] set_lvl,
  input  logic [NUM_LVL-1:0] ack_clr,
  output logic [NUM_LVL-1:0] req_q,
  output logic [NUM_LVL-1:0] mask_q,
  output logic [PRIO_W-1:0]  prio_q,
  output logic               gie_q,
  output logic               fast_en_q,
  output logic [LVL_W-1:0]   fast_sel_q
);
  logic wr_req, wr_mask, wr_prio, wr_mode;
  logic [NUM_LVL-1:0] sw_keep;

  assign wr_req  = wr_en && (addr == ADDR_REQ);
  assign wr_mask = wr_en && (addr == ADDR_MASK);
  assign wr_prio = wr_en && (addr == ADDR_PRIO);
  assign wr_mode = wr_en && (addr == ADDR_MODE);

  // Software may only clear; new events always win the edge
  assign sw_keep = wr_req ? wdata[NUM_LVL-1:0] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= '0;
      mask_q     <= '1;
      prio_q     <= '0;
      gie_q      <= 1'b0;
      fast_en_q  <= 1'b0;
      fast_sel_q <= '0;
    end else begin
      req_q <= (req_q & ~ack_clr & sw_keep) | set_lvl;
      if (wr_mask) mask_q <= wdata[NUM_LVL-1:0];
      if (wr_prio) prio_q <= wdata[PRIO_W-1:0];
      if (wr_mode) begin
        gie_q      <= wdata[0];
        fast_en_q  <= wdata[1];
        fast_sel_q <= wdata[LVL_W+1:2];
      end
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_REQ:  rdata = DATA_W'(req_q);
      ADDR_MASK: rdata = DATA_W'(mask_q);
      ADDR_PRIO: rdata = DATA_W'(prio_q);
      default:   rdata = DATA_W'({fast_sel_q, fast_en_q, gie_q});
    endcase
  end
endmodule

// File: rtl/irq_lvl_arbiter.sv
module irq_lvl_arbiter
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] pend,
  input  logic               gie,
  input  logic [PRIO_W-1:0]  prio,
  input  logic               fast_en,
  input  logic [LVL_W-1:0]   fast_sel,
  output logic               any,
  output logic [LVL_W-1:0]   lvl,
  output logic               fast
);
  logic desc;
  assign desc = (prio == PRIO_DESC);

  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    fast = 1'b0;
    if (gie) begin
      if (fast_en && pend[fast_sel]) begin
        any  = 1'b1;
        lvl  = fast_sel;
        fast = 1'b1;
      end else if (desc) begin
        for (int i = 0; i < NUM_LVL; i++)
          if (pend[i]) begin
            any = 1'b1;
            lvl = i[LVL_W-1:0];
          end
      end else begin
        for (int i = NUM_LVL - 1; i >= 0; i--)
          if (pend[i]) begin
            any = 1'b1;
            lvl = i[LVL_W-1:0];
          end
      end
    end
  end
endmodule

// File: rtl/irq_lvl_offer.sv
module irq_lvl_offer #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_any,
  input  logic [LVL_W-1:0] cand_lvl,
  input  logic             cand_fast,
  input  logic             ready,
  output logic             valid_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             fast_q,
  output logic             accept
);
  logic load;
  assign load   = !valid_q || ready;
  assign accept = valid_q && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lvl_q   <= '0;
      fast_q  <= 1'b0;
    end else if (load) begin
      valid_q <= cand_any;
      lvl_q   <= cand_lvl;
      fast_q  <= cand_fast;
    end
  end
endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC = 27,
  parameter int NUM_LVL = 8,
  parameter int DATA_W  = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [LVL_W-1:0]   irq_level,
  output logic               irq_fast
);
  logic [NUM_LVL-1:0] lvl_hit, set_lvl, ack_clr, req_q, mask_q, pend;
  logic [PRIO_W-1:0]  prio_q;
  logic               gie, fast_en, accept, cand_any, cand_fast;
  logic [LVL_W-1:0]   fast_sel, cand_lvl;

  irq_lvl_capture #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_cap (
    .src_req (src_req),
    .lvl_hit (lvl_hit)
  );

  assign set_lvl = lvl_hit & ~mask_q;

  always_comb begin
    ack_clr = '0;
    if (accept) ack_clr[irq_level] = 1'b1;
  end

  irq_lvl_regs #(.NUM_LVL(NUM_LVL), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .set_lvl    (set_lvl),
    .ack_clr    (ack_clr),
    .req_q      (req_q),
    .mask_q     (mask_q),
    .prio_q     (prio_q),
    .gie_q      (gie),
    .fast_en_q  (fast_en),
    .fast_sel_q (fast_sel)
  );

  // The level granted on this edge must not be offered again at once
  assign pend = req_q & ~mask_q & ~ack_clr;

  irq_lvl_arbiter #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_arb (
    .pend     (pend),
    .gie      (gie),
    .prio     (prio_q),
    .fast_en  (fast_en),
    .fast_sel (fast_sel),
    .any      (cand_any),
    .lvl      (cand_lvl),
    .fast     (cand_fast)
  );

  irq_lvl_offer #(.LVL_W(LVL_W)) u_offer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_any  (cand_any),
    .cand_lvl  (cand_lvl),
    .cand_fast (cand_fast),
    .ready     (irq_ready),
    .valid_q   (irq_valid),
    .lvl_q     (irq_level),
    .fast_q    (irq_fast),
    .accept    (accept)
  );
endmodule

// File: rtl/irq_lvl_ctrl_chk.sv
module irq_lvl_ctrl_chk #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [LVL_W-1:0]   irq_level,
  input logic               irq_fast,
  input logic [NUM_LVL-1:0] req_q,
  input logic [NUM_LVL-1:0] mask_q,
  input logic               gie,
  input logic [LVL_W-1:0]   fast_sel,
  input logic [NUM_LVL-1:0] lvl_hit
);
  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_level) && $stable(irq_fast)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !lvl_hit[irq_level]) |=> !req_q[$past(irq_level)]);

  // R3
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q) & $past(mask_q)) == '0));

  // R5
  offer_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(irq_valid) || $past(irq_ready)) && irq_valid) |-> $past(gie));

  // R11
  offer_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(irq_valid) || $past(irq_ready)) && irq_valid) |->
      ((($past(req_q & ~mask_q) >> irq_level) & NUM_LVL'(1)) != '0));

  // R7
  fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(irq_valid) || $past(irq_ready)) && irq_valid && irq_fast) |->
      (irq_level == $past(fast_sel)));
endmodule

bind irq_lvl_ctrl irq_lvl_ctrl_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_valid (irq_valid),
  .irq_ready (irq_ready),
  .irq_level (irq_level),
  .irq_fast  (irq_fast),
  .req_q     (req_q),
  .mask_q    (mask_q),
  .gie       (gie),
  .fast_sel  (fast_sel),
  .lvl_hit   (lvl_hit)
);

// File: tb/irq_lvl_ctrl_test.sv
module irq_lvl_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [26:0] src_req = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [2:0]  irq_level;
  logic        irq_fast;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_lvl_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_level(irq_level), .irq_fast(irq_fast)
  );

  typedef struct packed {
    logic [26:0] src;
    logic [7:0]  mask;
    logic [2:0]  prio;
    logic [4:0]  mode;
    logic        ev;
    logic [2:0]  el;
    logic        ef;
    logic [7:0]  ereq;
  } vec_t;

  // src level = floor(i*8/27); expected results worked out from R2..R7
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{27'h2000020, 8'h00, 3'd0, 5'h01, 1'b1, 3'd1, 1'b0, 8'h82}, // R2 R6 ascending
    '{27'h2000020, 8'h00, 3'd7, 5'h01, 1'b1, 3'd7, 1'b0, 8'h82}, // R6 descending
    '{27'h2000020, 8'h00, 3'd3, 5'h01, 1'b1, 3'd1, 1'b0, 8'h82}, // R6 reserved code
    '{27'h2000020, 8'h02, 3'd0, 5'h01, 1'b1, 3'd7, 1'b0, 8'h80}, // R3 masked level
    '{27'h0008001, 8'h00, 3'd0, 5'h13, 1'b1, 3'd4, 1'b1, 8'h11}, // R7 fast wins
    '{27'h0400001, 8'h00, 3'd0, 5'h13, 1'b1, 3'd0, 1'b0, 8'h41}, // R7 fast not pending
    '{27'h0001000, 8'h00, 3'd0, 5'h00, 1'b0, 3'd0, 1'b0, 8'h08}, // R5 gie off
    '{27'h7FFFFFF, 8'hFF, 3'd0, 5'h01, 1'b0, 3'd0, 1'b0, 8'h00}, // R3 all masked
    '{27'h7FFFFFF, 8'h00, 3'd7, 5'h0B, 1'b1, 3'd2, 1'b1, 8'hFF}, // R7 fast over desc
    '{27'h5800000, 8'h00, 3'd0, 5'h01, 1'b1, 3'd6, 1'b0, 8'hC0}, // R2 upper edge
    '{27'h0000018, 8'h01, 3'd0, 5'h01, 1'b1, 3'd1, 1'b0, 8'h02}, // R2 boundary 3/4
    '{27'h0000C00, 8'h00, 3'd7, 5'h01, 1'b1, 3'd3, 1'b0, 8'h0C}, // R2 boundary 10/11
    '{27'h0008001, 8'h00, 3'd0, 5'h12, 1'b0, 3'd0, 1'b0, 8'h11}  // R5 fast but gie off
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; reg_wr_en = 1'b0; irq_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [26:0] s);
    src_req = s;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic check_offer(input string tag, input logic v, input logic [2:0] l, input logic f);
    check({tag, " valid"}, irq_valid, v);
    if (v) begin
      check({tag, " level"}, irq_level, l);
      check({tag, " fast"}, irq_fast, f);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 / R9: reset values through the register port
    do_reset();
    check("R1 valid", irq_valid, 1'b0);
    rd_check("R1 req", 2'd0, 8'h00);
    rd_check("R1 mask", 2'd1, 8'hFF);
    rd_check("R1 prio", 2'd2, 8'h00);
    rd_check("R1 mode", 2'd3, 8'h00);

    // Vector table: R2 R3 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(2'd1, VECS[k].mask);
      wr(2'd2, {5'b0, VECS[k].prio});
      wr(2'd3, {3'b0, VECS[k].mode});
      pulse(VECS[k].src);
      @(negedge clk);
      check_offer($sformatf("R6/R7 vec%0d", k), VECS[k].ev, VECS[k].el, VECS[k].ef);
      rd_check($sformatf("R2/R3 vec%0d req", k), 2'd0, VECS[k].ereq);
    end

    // R9: unused bits dropped
    do_reset();
    wr(2'd3, 8'hFF); rd_check("R9 mode", 2'd3, 8'h1F);
    wr(2'd2, 8'hFF); rd_check("R9 prio", 2'd2, 8'h07);
    wr(2'd1, 8'h5A); rd_check("R9 mask", 2'd1, 8'h5A);

    // R4: software clears only
    do_reset();
    wr(2'd1, 8'h00);
    pulse(27'h2000020);
    rd_check("R4 latched", 2'd0, 8'h82);
    wr(2'd0, 8'hFD); rd_check("R4 clear bit1", 2'd0, 8'h80);
    wr(2'd0, 8'hFF); rd_check("R4 no set", 2'd0, 8'h80);
    wr(2'd0, 8'h7F); rd_check("R4 clear bit7", 2'd0, 8'h00);
    check("R5 no offer", irq_valid, 1'b0);

    // R11: latency
    do_reset();
    wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    pulse(27'h0000020);
    check("R11 not yet", irq_valid, 1'b0);
    rd_check("R11 req", 2'd0, 8'h02);
    @(negedge clk);
    check_offer("R11 offer", 1'b1, 3'd1, 1'b0);

    // R8: hold under back-pressure, then drain
    do_reset();
    wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    pulse(27'h2000020);
    @(negedge clk);
    check_offer("R8 first", 1'b1, 3'd1, 1'b0);
    pulse(27'h0000001);
    @(negedge clk);
    check_offer("R8 held", 1'b1, 3'd1, 1'b0);
    rd_check("R8 pend", 2'd0, 8'h83);
    irq_ready = 1'b1;
    @(negedge clk);
    check_offer("R8 next L0", 1'b1, 3'd0, 1'b0);
    rd_check("R8 req a", 2'd0, 8'h81);
    @(negedge clk);
    check_offer("R8 next L7", 1'b1, 3'd7, 1'b0);
    rd_check("R8 req b", 2'd0, 8'h80);
    @(negedge clk);
    check("R8 drained", irq_valid, 1'b0);
    rd_check("R8 req c", 2'd0, 8'h00);
    irq_ready = 1'b0;

    // R10: set beats software clear and acceptance clear
    do_reset();
    wr(2'd1, 8'h00);
    src_req = 27'h0000020;
    wr(2'd0, 8'h00);
    rd_check("R10 sw clear", 2'd0, 8'h02);
    src_req = '0;
    wr(2'd3, 8'h01);
    @(negedge clk);
    check_offer("R10 offer", 1'b1, 3'd1, 1'b0);
    src_req = 27'h0000020; irq_ready = 1'b1;
    @(negedge clk);
    src_req = '0; irq_ready = 1'b0;
    rd_check("R10 ack clear", 2'd0, 8'h02);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule